// File: doc/BRIEF.md
# USB OUT Endpoint Handshake Controller

This block decides how one full-speed USB device endpoint answers the OUT transactions aimed at it. A token decoder upstream tells it when an OUT token for this endpoint has arrived and when the following data packet has finished. The packet comes with its received PID parity, its byte count, the free space left in the receive FIFO and the current frame number. One cycle after the end of the data packet the block gives its verdict. That verdict has three parts: the handshake to send (none, ACK, NAK or STALL), whether the packet's bytes are committed to the FIFO or thrown away, and which interrupt flags to raise.

Software controls the endpoint through level inputs: active, transfer type, stall, odd/even frame select and maximum packet length. It also has three one-cycle commands: set NAK, clear NAK and reset the expected PID to DATA0. The block owns two pieces of state. The first is the NAK state, which software can only change through the two NAK commands. The second is the expected data toggle, which the block advances itself on every accepted bulk or interrupt packet. Isochronous packets are filtered by frame parity and never get a handshake.

Top module: `out_ep_handshake`

## Requirements
- R1: While `cfgActive` is 0, a data packet produces no handshake (`hsKind` 00), no accept, no drop and no flag, and an OUT token does not arm the endpoint.
- R2: A data packet is evaluated only if an OUT token arrived while the endpoint was active and no other data packet has arrived since that token. Any other data packet gets no handshake, no accept and no drop.
- R3: `cfgType` 01 selects isochronous. 10 selects bulk and 11 selects interrupt. Code 00 follows the bulk rules.
- R4: For a non-isochronous packet with `cfgStall` set, the handshake is STALL (`hsKind` 11) and the data is dropped. This holds whatever the NAK state and `globalOutNak` are, and the packet sets flag bit 1.
- R5: If stall is clear and either `nakState` or `globalOutNak` is 1, a non-isochronous packet gets NAK (`hsKind` 10) and its data is dropped.
- R6: `nakState` is 0 after reset. `cmdSetNak` makes it 1 one cycle later, and `cmdClearNak` makes it 0. If both commands come together, the set wins. With no command, `nakState` holds.
- R7: A packet whose byte count exceeds `cfgMaxLen` or `fifoSpace` is dropped. For a non-isochronous packet the handshake is NAK and the toggle is unchanged. An isochronous packet rejected this way raises no flag.
- R8: A non-isochronous packet that passes R4, R5 and R7 and whose `dataPid` (0 DATA0, 1 DATA1) equals `expPid` gets ACK (`hsKind` 01) and `dataAccept`. `expPid` then inverts and flag bit 0 is set. All of these are visible one cycle after `dataValid`.
- R9: A non-isochronous packet with a PID that does not match `expPid` gets ACK, its data is dropped, and `expPid` is unchanged.
- R10: `cmdSetData0` makes `expPid` 0 one cycle later, even when a toggle falls in the same cycle.
- R11: An isochronous packet never gets a handshake. If `frameNum[0]` differs from `cfgOddFrame` (0 even, 1 odd), the packet is dropped and flag bit 2 is set. Otherwise, if R7 passes, the packet is accepted and flag bit 0 is set.
- R12: `flags` reset to 0. Writing 1 to a bit of `flagClr` clears that flag one cycle later. A hardware set in the same cycle as a clear of the same bit leaves that bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgActive | input | 1 | Endpoint active |
| cfgType | input | 2 | Transfer type code |
| cfgStall | input | 1 | Endpoint stalled |
| cfgOddFrame | input | 1 | Isochronous frame parity select |
| cfgMaxLen | input | LEN_W | Maximum packet length in bytes |
| cmdSetNak | input | 1 | Set-NAK command pulse |
| cmdClearNak | input | 1 | Clear-NAK command pulse |
| cmdSetData0 | input | 1 | Reset expected PID to DATA0 |
| globalOutNak | input | 1 | Device-wide OUT NAK condition |
| tokenValid | input | 1 | OUT token for this endpoint |
| dataValid | input | 1 | End of data packet |
| dataPid | input | 1 | Received PID, 0 DATA0, 1 DATA1 |
| dataLen | input | LEN_W | Received byte count |
| fifoSpace | input | LEN_W | Free receive FIFO bytes |
| frameNum | input | FRAME_W | Current frame number |
| flagClr | input | 3 | Write-1-to-clear mask for flags |
| hsKind | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK, 11 STALL |
| dataAccept | output | 1 | Commit packet data |
| dataDrop | output | 1 | Discard packet data |
| nakState | output | 1 | Current NAK state |
| expPid | output | 1 | Expected data PID |
| flags | output | 3 | Bit0 accepted, bit1 stall sent, bit2 iso parity drop |

## Verification
The two functions that can meet in one cycle are the hardware setting of a flag by a packet verdict and the software's write-1-to-clear of the same bit. The bench provokes this by driving a nonzero `flagClr` in the same cycle as `dataValid` for a packet that will be accepted. It then expects the accepted flag to stay 1 while the other cleared bits fall. The reset of the toggle to DATA0 is also driven in the same cycle as an accepting packet, and `expPid` is expected to be 0 afterwards.

// File: rtl/out_ep_pkg.sv
package out_ep_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  localparam logic [1:0] XFER_ISO = 2'b01;

  localparam int FLAG_W       = 3;
  localparam int FLAG_DONE    = 0;
  localparam int FLAG_STALL   = 1;
  localparam int FLAG_ISODROP = 2;

  typedef struct packed {
    hs_e              hs;
    logic             accept;
    logic             drop;
    logic             toggle;
    logic             disarm;
    logic [FLAG_W-1:0] flagSet;
  } strobe_t;
endpackage

// File: rtl/out_ep_decide.sv
module out_ep_decide
  import out_ep_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int FRAME_W = 11
) (
  input  logic               dataValid,
  input  logic               armed,
  input  logic               active,
  input  logic [1:0]         xferType,
  input  logic               stall,
  input  logic               globalNak,
  input  logic               nakState,
  input  logic               oddSel,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               dataPid,
  input  logic               expPid,
  input  logic [LEN_W-1:0]   dataLen,
  input  logic [LEN_W-1:0]   maxLen,
  input  logic [LEN_W-1:0]   fifoSpace,
  output strobe_t            stb
);
  logic live;
  logic isIso;
  logic tooBig;
  logic parityBad;
  logic unusedFrameHi;

  assign live          = dataValid && armed && active;
  assign isIso         = (xferType == XFER_ISO);
  assign tooBig        = (dataLen > maxLen) || (dataLen > fifoSpace);
  assign parityBad     = (frameNum[0] != oddSel);
  assign unusedFrameHi = ^frameNum[FRAME_W-1:1];

  always_comb begin
    stb        = '0;
    stb.hs     = HS_NONE;
    stb.disarm = dataValid;
    if (live) begin
      if (isIso) begin
        if (parityBad) begin
          stb.drop                  = 1'b1;
          stb.flagSet[FLAG_ISODROP] = 1'b1;
        end else if (tooBig) begin
          stb.drop = 1'b1;
        end else begin
          stb.accept             = 1'b1;
          stb.flagSet[FLAG_DONE] = 1'b1;
        end
      end else if (stall) begin
        stb.hs                  = HS_STALL;
        stb.drop                = 1'b1;
        stb.flagSet[FLAG_STALL] = 1'b1;
      end else if (nakState || globalNak || tooBig) begin
        stb.hs   = HS_NAK;
        stb.drop = 1'b1;
      end else if (dataPid != expPid) begin
        stb.hs   = HS_ACK;
        stb.drop = 1'b1;
      end else begin
        stb.hs                 = HS_ACK;
        stb.accept             = 1'b1;
        stb.toggle             = 1'b1;
        stb.flagSet[FLAG_DONE] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/out_ep_state.sv
module out_ep_state
  import out_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokenValid,
  input  logic              active,
  input  logic              cmdSetNak,
  input  logic              cmdClearNak,
  input  logic              cmdSetData0,
  input  logic [FLAG_W-1:0] flagClr,
  input  strobe_t           stb,
  output logic              armed,
  output logic              nakState,
  output logic              expPid,
  output logic [FLAG_W-1:0] flags,
  output logic [1:0]        hsKind,
  output logic              dataAccept,
  output logic              dataDrop
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed      <= 1'b0;
      nakState   <= 1'b0;
      expPid     <= 1'b0;
      flags      <= '0;
      hsKind     <= HS_NONE;
      dataAccept <= 1'b0;
      dataDrop   <= 1'b0;
    end else begin
      if (tokenValid && active) armed <= 1'b1;
      else if (stb.disarm)      armed <= 1'b0;

      if (cmdSetNak)        nakState <= 1'b1;
      else if (cmdClearNak) nakState <= 1'b0;

      if (cmdSetData0)     expPid <= 1'b0;
      else if (stb.toggle) expPid <= ~expPid;

      flags      <= (flags & ~flagClr) | stb.flagSet;
      hsKind     <= stb.hs;
      dataAccept <= stb.accept;
      dataDrop   <= stb.drop;
    end
  end
endmodule

// File: rtl/out_ep_handshake.sv
module out_ep_handshake
  import out_ep_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgActive,
  input  logic [1:0]         cfgType,
  input  logic               cfgStall,
  input  logic               cfgOddFrame,
  input  logic [LEN_W-1:0]   cfgMaxLen,
  input  logic               cmdSetNak,
  input  logic               cmdClearNak,
  input  logic               cmdSetData0,
  input  logic               globalOutNak,
  input  logic               tokenValid,
  input  logic               dataValid,
  input  logic               dataPid,
  input  logic [LEN_W-1:0]   dataLen,
  input  logic [LEN_W-1:0]   fifoSpace,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic [2:0]         flagClr,
  output logic [1:0]         hsKind,
  output logic               dataAccept,
  output logic               dataDrop,
  output logic               nakState,
  output logic               expPid,
  output logic [2:0]         flags
);
  strobe_t stb;
  logic    armedW;

  out_ep_decide #(.LEN_W(LEN_W), .FRAME_W(FRAME_W)) u_decide (
    .dataValid (dataValid),
    .armed     (armedW),
    .active    (cfgActive),
    .xferType  (cfgType),
    .stall     (cfgStall),
    .globalNak (globalOutNak),
    .nakState  (nakState),
    .oddSel    (cfgOddFrame),
    .frameNum  (frameNum),
    .dataPid   (dataPid),
    .expPid    (expPid),
    .dataLen   (dataLen),
    .maxLen    (cfgMaxLen),
    .fifoSpace (fifoSpace),
    .stb       (stb)
  );

  out_ep_state u_state (
    .clk         (clk),
    .rstN        (rstN),
    .tokenValid  (tokenValid),
    .active      (cfgActive),
    .cmdSetNak   (cmdSetNak),
    .cmdClearNak (cmdClearNak),
    .cmdSetData0 (cmdSetData0),
    .flagClr     (flagClr),
    .stb         (stb),
    .armed       (armedW),
    .nakState    (nakState),
    .expPid      (expPid),
    .flags       (flags),
    .hsKind      (hsKind),
    .dataAccept  (dataAccept),
    .dataDrop    (dataDrop)
  );
endmodule

// File: rtl/out_ep_handshake_chk.sv
module out_ep_handshake_chk
  import out_ep_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cfgActive,
  input logic [1:0] cfgType,
  input logic       cfgStall,
  input logic       cmdSetNak,
  input logic       cmdClearNak,
  input logic       cmdSetData0,
  input logic       globalOutNak,
  input logic       dataValid,
  input logic       armedW,
  input logic [1:0] hsKind,
  input logic       dataAccept,
  input logic       dataDrop,
  input logic       nakState,
  input logic       expPid,
  input logic [2:0] flags
);
  assert_inactive_silent_R1: assert property (@(posedge clk) disable iff (!rstN)
    dataValid && !cfgActive |=> hsKind == HS_NONE && !dataAccept && !dataDrop);

  assert_unarmed_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    dataValid && !armedW |=> hsKind == HS_NONE && !dataAccept && !dataDrop);

  assert_stall_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataValid && armedW && cfgActive && cfgStall && cfgType != XFER_ISO
    |=> hsKind == HS_STALL && dataDrop && flags[FLAG_STALL]);

  assert_nak_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    dataValid && armedW && cfgActive && !cfgStall && cfgType != XFER_ISO
    && (nakState || globalOutNak) |=> hsKind == HS_NAK && dataDrop);

  assert_nak_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdSetNak |=> nakState);

  assert_nak_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdClearNak && !cmdSetNak |=> !nakState);

  assert_nak_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cmdSetNak && !cmdClearNak |=> $stable(nakState));

  assert_accept_drop_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(dataAccept && dataDrop));

  assert_accept_no_refusal_R8: assert property (@(posedge clk) disable iff (!rstN)
    dataAccept |-> hsKind == HS_ACK || hsKind == HS_NONE);

  assert_data0_cmd_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdSetData0 |=> !expPid);

  assert_iso_silent_R11: assert property (@(posedge clk) disable iff (!rstN)
    dataValid && cfgType == XFER_ISO |=> hsKind == HS_NONE);

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rstN)
    dataAccept |-> flags[FLAG_DONE]);
endmodule

bind out_ep_handshake out_ep_handshake_chk u_chk (.*);

// File: tb/out_ep_handshake_tb.sv
module out_ep_handshake_tb;
  import out_ep_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        cfgActive = 1'b0;
  logic [1:0]  cfgType = 2'b10;
  logic        cfgStall = 1'b0;
  logic        cfgOddFrame = 1'b0;
  logic [10:0] cfgMaxLen = 11'd64;
  logic        cmdSetNak = 1'b0;
  logic        cmdClearNak = 1'b0;
  logic        cmdSetData0 = 1'b0;
  logic        globalOutNak = 1'b0;
  logic        tokenValid = 1'b0;
  logic        dataValid = 1'b0;
  logic        dataPid = 1'b0;
  logic [10:0] dataLen = '0;
  logic [10:0] fifoSpace = 11'd512;
  logic [10:0] frameNum = '0;
  logic [2:0]  flagClr = '0;
  logic [1:0]  hsKind;
  logic        dataAccept;
  logic        dataDrop;
  logic        nakState;
  logic        expPid;
  logic [2:0]  flags;

  out_ep_handshake u_dut (.*);

  int checks = 0;
  int failures = 0;

  typedef struct {
    string      req;
    logic [1:0] hs;
    logic       acc;
    logic       drp;
    logic       pid;
    logic [2:0] fl;
  } exp_t;

  exp_t scoreQ[$];

  logic       mPid = 1'b0;
  logic       mNak = 1'b0;
  logic       mArmed = 1'b0;
  logic [2:0] mFlags = '0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (scoreQ.size() > 0) begin
      e = scoreQ.pop_front();
      chk({e.req, " hsKind"}, int'(hsKind), int'(e.hs));
      chk({e.req, " accept"}, int'(dataAccept), int'(e.acc));
      chk({e.req, " drop"}, int'(dataDrop), int'(e.drp));
      chk({e.req, " expPid"}, int'(expPid), int'(e.pid));
      chk({e.req, " flags"}, int'(flags), int'(e.fl));
    end
  end

  // Drives an optional OUT token then one data packet; the expected
  // verdict is worked out from the requirements and queued.
  task automatic sendPkt(string req, bit tok, logic pid, int len,
                         logic [2:0] clr, bit d0);
    exp_t e;
    logic tog;
    logic [2:0] setF;
    logic over;
    if (tok) begin
      tokenValid = 1'b1;
      @(negedge clk);
      tokenValid = 1'b0;
      if (cfgActive) mArmed = 1'b1;
    end
    e.req = req; e.hs = 2'b00; e.acc = 1'b0; e.drp = 1'b0;
    tog = 1'b0; setF = 3'b000;
    over = (len > int'(cfgMaxLen)) || (len > int'(fifoSpace));
    if (mArmed && cfgActive) begin
      if (cfgType == 2'b01) begin
        if (frameNum[0] != cfgOddFrame) begin e.drp = 1'b1; setF = 3'b100; end
        else if (over) e.drp = 1'b1;
        else begin e.acc = 1'b1; setF = 3'b001; end
      end else if (cfgStall) begin
        e.hs = 2'b11; e.drp = 1'b1; setF = 3'b010;
      end else if (mNak || globalOutNak || over) begin
        e.hs = 2'b10; e.drp = 1'b1;
      end else if (pid != mPid) begin
        e.hs = 2'b01; e.drp = 1'b1;
      end else begin
        e.hs = 2'b01; e.acc = 1'b1; tog = 1'b1; setF = 3'b001;
      end
    end
    mArmed = 1'b0;
    if (d0) mPid = 1'b0;
    else if (tog) mPid = ~mPid;
    mFlags = (mFlags & ~clr) | setF;
    e.pid = mPid;
    e.fl  = mFlags;
    dataValid = 1'b1; dataPid = pid; dataLen = len[10:0];
    flagClr = clr; cmdSetData0 = d0;
    @(posedge clk);
    scoreQ.push_back(e);
    @(negedge clk);
    dataValid = 1'b0; flagClr = '0; cmdSetData0 = 1'b0;
  endtask

  task automatic nakCmd(string req, bit s, bit c);
    cmdSetNak = s; cmdClearNak = c;
    @(negedge clk);
    cmdSetNak = 1'b0; cmdClearNak = 1'b0;
    if (s) mNak = 1'b1;
    else if (c) mNak = 1'b0;
    chk({req, " nakState"}, int'(nakState), int'(mNak));
  endtask

  task automatic clearFlags(string req, logic [2:0] mask);
    flagClr = mask;
    @(negedge clk);
    flagClr = '0;
    mFlags = mFlags & ~mask;
    chk({req, " flags"}, int'(flags), int'(mFlags));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset nakState", int'(nakState), 0);
    chk("R10 reset expPid", int'(expPid), 0);
    chk("R12 reset flags", int'(flags), 0);
    chk("R8 reset hsKind", int'(hsKind), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: inactive endpoint ignores token and data
    sendPkt("R1 inactive", 1, 1'b0, 8, 3'b000, 0);
    cfgActive = 1'b1;
    // R1 token while inactive must not have armed: data now is unarmed
    sendPkt("R1 token not armed", 0, 1'b0, 8, 3'b000, 0);
    // R2: data with no preceding token
    sendPkt("R2 no token", 0, 1'b0, 8, 3'b000, 0);

    // R8 bulk match, R9 mismatch
    sendPkt("R8 bulk accept", 1, 1'b0, 10, 3'b000, 0);
    sendPkt("R9 pid mismatch", 1, 1'b0, 10, 3'b000, 0);
    sendPkt("R8 bulk accept data1", 1, 1'b1, 64, 3'b000, 0);
    // R2: second data after one token is ignored
    sendPkt("R2 second data", 0, 1'b0, 10, 3'b000, 0);

    // R7 oversize and FIFO short
    sendPkt("R7 over maxlen", 1, 1'b0, 65, 3'b000, 0);
    fifoSpace = 11'd5;
    sendPkt("R7 fifo short", 1, 1'b0, 10, 3'b000, 0);
    fifoSpace = 11'd512;

    // R6 NAK commands, R5 NAK handshake
    nakCmd("R6 set", 1, 0);
    sendPkt("R5 nak state", 1, 1'b0, 10, 3'b000, 0);
    nakCmd("R6 clear", 0, 1);
    nakCmd("R6 both set wins", 1, 1);
    nakCmd("R6 hold", 0, 0);
    nakCmd("R6 clear again", 0, 1);
    globalOutNak = 1'b1;
    sendPkt("R5 global nak", 1, 1'b0, 10, 3'b000, 0);
    globalOutNak = 1'b0;

    // R4 stall beats NAK
    nakCmd("R6 set for stall", 1, 0);
    cfgStall = 1'b1;
    sendPkt("R4 stall over nak", 1, 1'b0, 10, 3'b000, 0);
    cfgStall = 1'b0;
    nakCmd("R6 clear after stall", 0, 1);

    // R10 set DATA0
    sendPkt("R8 accept before d0", 1, 1'b0, 4, 3'b000, 0);
    cmdSetData0 = 1'b1;
    @(negedge clk);
    cmdSetData0 = 1'b0;
    mPid = 1'b0;
    chk("R10 set data0", int'(expPid), 0);
    sendPkt("R10 d0 with toggle", 1, 1'b0, 4, 3'b000, 1);

    // R3 interrupt and code 00 follow bulk rules
    cfgType = 2'b11;
    sendPkt("R3 interrupt accept", 1, 1'b0, 4, 3'b000, 0);
    cfgType = 2'b00;
    sendPkt("R3 code00 accept", 1, 1'b1, 4, 3'b000, 0);

    // R12 clear and same-cycle set
    clearFlags("R12 w1c", 3'b111);
    cfgType = 2'b10;
    sendPkt("R12 set wins", 1, mPid, 4, 3'b001, 0);
    clearFlags("R12 w1c done", 3'b001);

    // R11 isochronous
    cfgType = 2'b01;
    cfgStall = 1'b1;
    cfgOddFrame = 1'b1;
    frameNum = 11'd6;
    sendPkt("R11 iso parity drop", 1, 1'b0, 8, 3'b000, 0);
    frameNum = 11'd7;
    sendPkt("R11 iso accept", 1, 1'b1, 8, 3'b000, 0);
    sendPkt("R7 iso oversize", 1, 1'b0, 100, 3'b000, 0);
    cfgOddFrame = 1'b0;
    frameNum = 11'd8;
    sendPkt("R11 iso even accept", 1, 1'b0, 8, 3'b000, 0);
    cfgStall = 1'b0;

    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule